// File: doc/BRIEF.md
# Set-Associative Data Cache with Per-Word Valid Bits

This block is a four-way set-associative data cache. Each way holds 4 KiB as 256 lines of 16 bytes. A line carries an address tag and a separate valid bit for each of its four 32-bit words. A cacheable read that hits returns the stored word one cycle after it is accepted. A cacheable read that misses fetches only the requested word through a single-outstanding memory request/response port, and marks only that word valid, so a line can be partly valid.

Stores always go through to memory. A store updates the cached copy only when that word is already present, and it never allocates a line. When no way holds the tag, the way to refill is the least recently used one in the set, using true LRU order. A one-cycle flush pulse clears every valid bit by walking the sets. New requests are held off until the walk is done.

Requests use word addresses: `req_waddr` carries byte-address bits [31:2]. The block accepts one request at a time. It signals that it is free on `req_ready` and gives exactly one response pulse per request.

Top module: `dcache_core`

## Requirements
- R1: In byte-address terms, bits [31:12] form the tag, bits [11:4] pick one of 256 sets and bits [3:2] pick one of four words. Every memory request carries the word address of the accepted request unchanged on `mem_req_waddr`.
- R2: A cacheable read hits when a way has a line with at least one valid word, a matching tag and the addressed word valid. It then raises `rsp_valid` with the cached word in the cycle after acceptance, and raises no memory request.
- R3: A cacheable read miss raises `mem_req_valid` (write flag 0) in the cycle after acceptance and holds it until `mem_rsp_valid`. In the cycle after that, the block returns the memory word and marks only that word valid.
- R4: If the tag matches a line with some valid words but the addressed word is invalid, the fill goes into that same way. The line's other valid words are kept and still hit.
- R5: If no way holds the tag, the fill replaces the true-LRU way of the set. The recency order is updated by a read hit, a successful fill and a cacheable store hit, and by nothing else.
- R6: A read fill whose response has `mem_rsp_err` set returns `rsp_err`=1 and `rsp_trap`=0x09. It sets no valid bit and changes neither the data, the tags nor the recency order, so the same read misses again.
- R7: Every store issues a memory write (write flag 1, store data on `mem_req_wdata`). A cacheable store that hits also updates the cached word. A store that misses allocates nothing, including a store to a matching tag whose word is invalid.
- R8: A store whose response carries an error returns `rsp_err`=1 and `rsp_trap`=0x2B. The cache update made by a store hit is kept.
- R9: A read with `req_cacheable`=0 always goes to memory, even if the word is cached, and returns the memory word. Tags, valid bits, data and recency order are unchanged.
- R10: A `flush_req` pulse forces `req_ready` low from the next cycle and clears every valid bit. `req_ready` returns within 258 cycles of the pulse.
- R11: `req_ready` is low while a memory access is outstanding and while a flush is pending or running.
- R12: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0, and all lines are invalid. The recency order makes successive misses into one set fill ways 3, 2, 1 and 0 in turn.
- R13: `rsp_valid` is a single-cycle pulse. A response without error has `rsp_err`=0 and `rsp_trap`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_req | input | 1 | Pulse that invalidates all lines |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | Address may be cached |
| req_waddr | input | 30 | Word address (byte bits [31:2]) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Load data |
| rsp_err | output | 1 | Access error |
| rsp_trap | output | 8 | Trap code: 0x09 load error, 0x2B store error, else 0 |
| mem_req_valid | output | 1 | Memory access outstanding |
| mem_req_write | output | 1 | Memory access is a write |
| mem_req_waddr | output | 30 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response, one cycle |
| mem_rsp_rdata | input | 32 | Memory read data |
| mem_rsp_err | input | 1 | Memory reported an error |

## Verification
The bench drives partial lines: it fills one word, then reads a neighbour in the same line. A design that evicted the line on a tag match would then miss on the first word. It builds a recency order in which plain FIFO and true LRU pick different victims, and it compares every eviction against a queue-based model. It also checks that error fills and uncached reads leave the set untouched, since a design that set a valid bit on an error would return garbage as a hit. A store whose write failed must still leave the updated word in the cache while an uncached read returns the old memory word. After a flush every earlier line must miss, and a short walk would show up as a stale hit.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MEM   = 2'd1,
        ST_FLUSH = 2'd2
    } dc_state_e;

    localparam logic [7:0] TRAP_NONE      = 8'h00;
    localparam logic [7:0] TRAP_LOAD_ERR  = 8'h09;
    localparam logic [7:0] TRAP_STORE_ERR = 8'h2B;
endpackage

// File: rtl/dcache_way.sv
// One way: tag, per-word valid bits and data, with asynchronous read.
module dcache_way #(
    parameter int SETS   = 256,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WORD_W-1:0] rd_word,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [WORDS-1:0]  rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              meta_we,
    input  logic [SET_W-1:0]  meta_set,
    input  logic [TAG_W-1:0]  meta_tag,
    input  logic [WORDS-1:0]  meta_valid,
    input  logic              clr_we,
    input  logic [SET_W-1:0]  clr_set,
    input  logic              dat_we,
    input  logic [SET_W-1:0]  dat_set,
    input  logic [WORD_W-1:0] dat_word,
    input  logic [DATA_W-1:0] dat_wdata
);
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [WORDS-1:0]  vld_mem [SETS];
    logic [DATA_W-1:0] dat_mem [SETS*WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
        end else begin
            if (clr_we)  vld_mem[clr_set]  <= '0;
            if (meta_we) vld_mem[meta_set] <= meta_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (meta_we) tag_mem[meta_set] <= meta_tag;
    end

    always_ff @(posedge clk) begin
        if (dat_we) dat_mem[{dat_set, dat_word}] <= dat_wdata;
    end

    assign rd_tag   = tag_mem[rd_set];
    assign rd_valid = vld_mem[rd_set];
    assign rd_data  = dat_mem[{rd_set, rd_word}];
endmodule

// File: rtl/dcache_lru.sv
// True LRU per set: each way keeps a recency rank, 0 = most recent.
module dcache_lru #(
    parameter int SETS = 256,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    output logic [WAY_W-1:0] victim_o,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way
);
    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic [WAY_W-1:0] touched_rank;

    assign touched_rank = rank_q[touch_set][touch_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[touch_set][w] <= '0;
                else if (rank_q[touch_set][w] < touched_rank)
                    rank_q[touch_set][w] <= rank_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++)
            if (rank_q[set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
    end
endmodule

// File: rtl/dcache_core.sv
module dcache_core #(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 4,
    parameter int WAY_BYTES  = 4096,
    parameter int LINE_BYTES = 16,
    localparam int DATA_W = 32,
    localparam int WA_W   = ADDR_W - 2,
    localparam int WORDS  = LINE_BYTES / 4,
    localparam int SETS   = WAY_BYTES / LINE_BYTES,
    localparam int WORD_W = $clog2(WORDS),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = WA_W - SET_W - WORD_W,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_cacheable,
    input  logic [WA_W-1:0]   req_waddr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [7:0]        rsp_trap,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [WA_W-1:0]   mem_req_waddr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              mem_rsp_err
);
    import dcache_pkg::*;

    typedef struct packed {
        dc_state_e         st;
        logic              flush_pend;
        logic [SET_W-1:0]  fcnt;
        logic [WA_W-1:0]   waddr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              cacheable;
        logic              merge;
        logic [WAY_W-1:0]  way;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_e;
        logic [7:0]        trap;
    } regs_t;

    regs_t q, d;

    // lookup address: live request when idle, latched one otherwise
    logic [WA_W-1:0]   la;
    logic [SET_W-1:0]  l_set;
    logic [WORD_W-1:0] l_word;
    logic [TAG_W-1:0]  l_tag;

    assign la     = (q.st == ST_IDLE) ? req_waddr : q.waddr;
    assign l_word = la[WORD_W-1:0];
    assign l_set  = la[WORD_W +: SET_W];
    assign l_tag  = la[WA_W-1 -: TAG_W];

    logic [TAG_W-1:0]  way_tag [WAYS];
    logic [WORDS-1:0]  way_vld [WAYS];
    logic [DATA_W-1:0] way_dat [WAYS];
    logic [WAYS-1:0]   meta_we, dat_we;
    logic [TAG_W-1:0]  meta_tag;
    logic [WORDS-1:0]  meta_valid;
    logic [DATA_W-1:0] dat_wdata;
    logic              clr_we;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dcache_way #(
            .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) way_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_set    (l_set),
            .rd_word   (l_word),
            .rd_tag    (way_tag[w]),
            .rd_valid  (way_vld[w]),
            .rd_data   (way_dat[w]),
            .meta_we   (meta_we[w]),
            .meta_set  (l_set),
            .meta_tag  (meta_tag),
            .meta_valid(meta_valid),
            .clr_we    (clr_we),
            .clr_set   (q.fcnt),
            .dat_we    (dat_we[w]),
            .dat_set   (l_set),
            .dat_word  (l_word),
            .dat_wdata (dat_wdata)
        );
    end

    logic [WAY_W-1:0] victim, pres_way, touch_way;
    logic             any_present, hit, touch_en;

    dcache_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (l_set),
        .victim_o (victim),
        .touch_en (touch_en),
        .touch_set(l_set),
        .touch_way(touch_way)
    );

    always_comb begin
        any_present = 1'b0;
        hit         = 1'b0;
        pres_way    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if ((|way_vld[w]) && (way_tag[w] == l_tag)) begin
                any_present = 1'b1;
                pres_way    = WAY_W'(w);
                hit         = way_vld[w][l_word];
            end
        end
    end

    always_comb begin
        d          = q;
        d.rsp_v    = 1'b0;
        d.rsp_e    = 1'b0;
        d.trap     = TRAP_NONE;
        meta_we    = '0;
        dat_we     = '0;
        meta_tag   = l_tag;
        meta_valid = '0;
        dat_wdata  = req_wdata;
        clr_we     = 1'b0;
        touch_en   = 1'b0;
        touch_way  = pres_way;
        if (flush_req) d.flush_pend = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (q.flush_pend) begin
                    d.st         = ST_FLUSH;
                    d.fcnt       = '0;
                    d.flush_pend = flush_req;
                end else if (req_valid) begin
                    d.waddr     = req_waddr;
                    d.wr        = req_write;
                    d.wdata     = req_wdata;
                    d.cacheable = req_cacheable;
                    d.merge     = any_present;
                    d.way       = any_present ? pres_way : victim;
                    if (!req_write && req_cacheable && hit) begin
                        d.rsp_v    = 1'b1;
                        d.rsp_data = way_dat[pres_way];
                        touch_en   = 1'b1;
                    end else begin
                        d.st = ST_MEM;
                        if (req_write && req_cacheable && hit) begin
                            dat_we[pres_way] = 1'b1;
                            touch_en         = 1'b1;
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_rsp_valid) begin
                    d.st       = ST_IDLE;
                    d.rsp_v    = 1'b1;
                    d.rsp_data = mem_rsp_rdata;
                    d.rsp_e    = mem_rsp_err;
                    if (mem_rsp_err) d.trap = q.wr ? TRAP_STORE_ERR : TRAP_LOAD_ERR;
                    if (!q.wr && q.cacheable && !mem_rsp_err) begin
                        meta_we[q.way] = 1'b1;
                        meta_valid     = (q.merge ? way_vld[q.way] : '0)
                                       | (WORDS'(1) << l_word);
                        dat_we[q.way]  = 1'b1;
                        dat_wdata      = mem_rsp_rdata;
                        touch_en       = 1'b1;
                        touch_way      = q.way;
                    end
                end
            end
            ST_FLUSH: begin
                clr_we = 1'b1;
                d.fcnt = q.fcnt + 1'b1;
                if (q.fcnt == SET_W'(SETS - 1)) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE) && !q.flush_pend;
    assign rsp_valid     = q.rsp_v;
    assign rsp_rdata     = q.rsp_data;
    assign rsp_err       = q.rsp_e;
    assign rsp_trap      = q.trap;
    assign mem_req_valid = (q.st == ST_MEM);
    assign mem_req_write = q.wr;
    assign mem_req_waddr = q.waddr;
    assign mem_req_wdata = q.wdata;
endmodule

// File: rtl/dcache_core_chk.sv
module dcache_core_chk #(
    parameter int WA_W = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush_req,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic [7:0]      rsp_trap,
    input logic            mem_req_valid,
    input logic [WA_W-1:0] mem_req_waddr,
    input logic            mem_rsp_valid
);
    import dcache_pkg::*;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> (rsp_valid != mem_req_valid)); // R2

    AST_MEM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && $past(mem_req_valid) |-> $stable(mem_req_waddr)); // R3

    AST_MEM_DONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_rsp_valid |=> rsp_valid && !mem_req_valid); // R3

    AST_ERR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> (rsp_trap == TRAP_LOAD_ERR || rsp_trap == TRAP_STORE_ERR)); // R6

    AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !req_ready); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R11

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R13

    AST_CLEAN_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_err |-> rsp_trap == TRAP_NONE); // R13
endmodule

bind dcache_core dcache_core_chk #(.WA_W(WA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_req    (flush_req),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_trap     (rsp_trap),
    .mem_req_valid(mem_req_valid),
    .mem_req_waddr(mem_req_waddr),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/dcache_core_tb.sv
module dcache_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_req = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_cacheable = 1'b0;
    logic [29:0] req_waddr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [7:0]  rsp_trap;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [29:0] mem_req_waddr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        mem_rsp_err = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    dcache_core dut_i (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cacheable(req_cacheable), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_trap(rsp_trap),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_waddr(mem_req_waddr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference: tags, valid masks, sparse data, recency queues
    logic [19:0] m_tag [4][256];
    logic [3:0]  m_vld [4][256];
    logic [31:0] m_dat [int];
    int          m_ord [256][$];
    logic [31:0] mem_st [int];

    function automatic logic [31:0] memword(logic [29:0] wa);
        if (mem_st.exists(int'(wa))) return mem_st[int'(wa)];
        return ({2'b00, wa} * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [29:0] mk(int tg, int s, int wo);
        return {tg[19:0], s[7:0], wo[1:0]};
    endfunction

    function automatic int dkey(int w, int s, int wo);
        return w * 1024 + s * 4 + wo;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string rq, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic touch(int s, int w);
        for (int i = 0; i < m_ord[s].size(); i++) begin
            if (m_ord[s][i] == w) begin
                m_ord[s].delete(i);
                break;
            end
        end
        m_ord[s].push_front(w);
    endtask

    task automatic access(bit wr, logic [29:0] wa, logic [31:0] wd, bit cach,
                          int lat, bit err, string rq);
        int s, wo, pw, fw;
        logic [19:0] tg;
        bit hit;
        logic [31:0] mw;
        s  = int'(wa[9:2]);
        wo = int'(wa[1:0]);
        tg = wa[29:10];
        pw = -1;
        for (int w = 0; w < 4; w++)
            if (m_vld[w][s] != 4'b0 && m_tag[w][s] == tg) pw = w;
        hit = 1'b0;
        if (pw >= 0) hit = m_vld[pw][s][wo];
        mw = memword(wa);
        chk({31'b0, req_ready}, 32'd1, "R11", "ready before request");
        req_valid = 1'b1; req_write = wr; req_cacheable = cach;
        req_waddr = wa;   req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!wr && cach && hit) begin
            chk({31'b0, rsp_valid}, 32'd1, "R2", "hit response");
            chk(rsp_rdata, m_dat[dkey(pw, s, wo)], "R2", "hit data");
            chk({31'b0, mem_req_valid}, 32'd0, "R2", "no memory access on hit");
            touch(s, pw);
        end else begin
            if (wr && cach && hit) begin
                m_dat[dkey(pw, s, wo)] = wd;
                touch(s, pw);
            end
            chk({31'b0, mem_req_valid}, 32'd1, rq, "memory request raised");
            chk({2'b0, mem_req_waddr}, {2'b0, wa}, "R1", "memory word address");
            chk({31'b0, mem_req_write}, {31'b0, wr}, rq, "memory write flag");
            if (wr) chk(mem_req_wdata, wd, "R7", "write-through data");
            chk({31'b0, rsp_valid}, 32'd0, rsp_valid ? rq : "R13", "no early response");
            for (int i = 1; i < lat; i++) begin
                @(posedge clk); #1;
                chk({31'b0, mem_req_valid}, 32'd1, "R3", "request held");
                chk({31'b0, req_ready}, 32'd0, "R11", "stalled while busy");
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = wr ? 32'hDEAD_BEEF : mw;
            mem_rsp_err   = err;
            @(posedge clk); #1;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            chk({31'b0, rsp_valid}, 32'd1, rq, "response after memory");
            chk({31'b0, rsp_err}, {31'b0, err}, err ? (wr ? "R8" : "R6") : "R13", "error flag");
            chk({24'b0, rsp_trap}, err ? (wr ? 32'h2B : 32'h09) : 32'h0,
                err ? (wr ? "R8" : "R6") : "R13", "trap code");
            if (!wr && !err) chk(rsp_rdata, mw, cach ? "R3" : "R9", "memory data returned");
            chk({31'b0, mem_req_valid}, 32'd0, "R11", "request dropped");
            if (wr && !err) mem_st[int'(wa)] = wd;
            if (!wr && cach && !err) begin
                if (pw >= 0) fw = pw;
                else begin
                    fw = m_ord[s][m_ord[s].size() - 1];
                    m_vld[fw][s] = 4'b0;
                    m_tag[fw][s] = tg;
                end
                m_vld[fw][s][wo] = 1'b1;
                m_dat[dkey(fw, s, wo)] = mw;
                touch(s, fw);
            end
        end
        @(posedge clk); #1;
        chk({31'b0, rsp_valid}, 32'd0, "R13", "response is one cycle");
    endtask

    task automatic do_flush();
        int n;
        flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
        chk({31'b0, req_ready}, 32'd0, "R10", "stall after flush pulse");
        n = 1;
        while (!req_ready && n < 400) begin
            @(posedge clk); #1;
            n++;
        end
        chk({31'b0, (n <= 258) ? 1'b1 : 1'b0}, 32'd1, "R10", "flush completes in bound");
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 256; s++) m_vld[w][s] = 4'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=%0d expected<=150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [29:0] a;
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 256; s++) begin
                m_vld[w][s] = 4'b0;
                m_tag[w][s] = '0;
            end
        for (int s = 0; s < 256; s++) m_ord[s] = {0, 1, 2, 3};

        repeat (3) @(posedge clk);
        #1;
        chk({31'b0, req_ready}, 32'd1, "R12", "reset ready");
        chk({31'b0, rsp_valid}, 32'd0, "R12", "reset no response");
        chk({31'b0, mem_req_valid}, 32'd0, "R12", "reset no memory request");
        rst_n = 1'b1;
        @(posedge clk); #1;

        a = mk(1, 5, 1);
        access(0, a, 0, 1, 3, 0, "R3");             // first miss fills way 3 (R12)
        access(0, a, 0, 1, 1, 0, "R2");             // hit
        access(0, mk(1, 5, 2), 0, 1, 2, 0, "R4");   // partial line fill, same way
        access(0, a, 0, 1, 1, 0, "R4");             // first word still hits
        access(0, mk(2, 5, 0), 0, 1, 1, 0, "R12");
        access(0, mk(3, 5, 0), 0, 1, 1, 0, "R12");
        access(0, mk(4, 5, 0), 0, 1, 1, 0, "R12");
        access(0, a, 0, 1, 1, 0, "R5");             // refresh oldest line
        access(0, mk(5, 5, 0), 0, 1, 2, 0, "R5");   // evicts tag 2, not tag 1
        access(0, mk(2, 5, 0), 0, 1, 1, 0, "R5");   // tag 2 now misses
        access(0, a, 0, 1, 1, 0, "R5");             // tag 1 still resident

        access(0, mk(7, 5, 3), 0, 1, 2, 1, "R6");   // load error
        access(0, mk(7, 5, 3), 0, 1, 1, 0, "R6");   // misses again

        access(1, a, 32'hCAFE_0001, 1, 2, 0, "R7"); // store hit
        access(0, a, 0, 1, 1, 0, "R7");             // returns stored value
        access(1, mk(9, 6, 0), 32'h1234_ABCD, 1, 1, 0, "R7"); // store miss
        access(0, mk(9, 6, 0), 0, 1, 1, 0, "R7");   // not allocated
        access(1, mk(1, 5, 3), 32'h0BAD_F00D, 1, 1, 0, "R7"); // tag match, word invalid
        access(0, mk(1, 5, 3), 0, 1, 1, 0, "R7");   // still a miss

        access(1, a, 32'hFEED_0002, 1, 2, 1, "R8"); // store error keeps cache update
        access(0, a, 0, 1, 1, 0, "R8");
        access(0, a, 0, 0, 2, 0, "R9");             // uncached read goes to memory
        access(0, a, 0, 1, 1, 0, "R9");             // cached value untouched

        do_flush();
        access(0, a, 0, 1, 1, 0, "R10");            // flushed line misses

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(49) == 0) do_flush();
            else begin
                bit wr, cach, er;
                int lat;
                logic [29:0] ra;
                ra   = mk($urandom_range(1, 6), ($urandom_range(1) == 0) ? 0 : 255,
                          $urandom_range(3));
                wr   = ($urandom_range(9) < 3);
                cach = ($urandom_range(19) != 0);
                er   = ($urandom_range(9) == 0);
                lat  = $urandom_range(1, 4);
                access(wr, ra, $urandom(), cach, lat, er, "R5");
            end
        end

        summary();
        $finish;
    end
endmodule